// File: doc/BRIEF.md
# Program Counter and Branch Sequencer

This block produces the instruction fetch address for a small Harvard-style core whose program memory is separate from its data memory. Each clock is one instruction cycle. While the instruction at address A executes, the instruction at A+1 is already being fetched. The decoder presents a short operation code for the executing instruction, and the sequencer decides where the next fetch goes. The choices are the next sequential address, a jump or call target, a saved return address, or a computed address built from a written low byte.

Conditional control exists only as a skip on one tested bit. A taken skip turns the already fetched instruction into a no-operation. A jump, call, return or low-byte write also discards the fetched instruction, so these cost two cycles. The upper address bits that a transfer field cannot supply come from a separately written high-bits latch. A four-level circular return stack holds call return addresses.

The controller is a two-state machine. `ST_RUN` means the executing instruction is live. `ST_BUBBLE` means it is nullified. Transitions:
- RUN→RUN: a non-transfer, non-skipping operation.
- RUN→BUBBLE: a taken skip or any transfer.
- BUBBLE→RUN: always.
- Reset enters BUBBLE.

Top module: `pcseq_top`

## Requirements
- R1: After reset, `fetch_addr` is 0, `squash` is 1, the high-bits latch is 0 and the stack pointer is at slot 0.
- R2: In a live cycle, op codes 0 (no transfer) and 1 (latch write) advance `fetch_addr` by one, modulo 2^13. `squash` is 0 in the following cycle.
- R3: Op 2 skips when `bit_val` is 1 and op 3 skips when `bit_val` is 0. A skip advances `fetch_addr` by one and raises `squash` for the next cycle. An untaken skip behaves as in R2.
- R4: Op 4 (jump) loads `fetch_addr` with latch bits 4:3 concatenated above the 11-bit `op_far`, and raises `squash` for the next cycle.
- R5: Op 5 (call) pushes the current `fetch_addr`, which is the address after the call. It then loads the same target as R4 and raises `squash`.
- R6: Op 6 (return) loads `fetch_addr` with the most recently pushed, not yet popped, address and raises `squash`.
- R7: Op 7 (low-byte write) loads `fetch_addr` with all five latch bits above the 8-bit `op_byte`, and raises `squash`.
- R8: Op 1 stores `op_byte[4:0]` into the high-bits latch. The new value is used by transfers in later cycles only.
- R9: While `squash` is 1, the presented op code is ignored. The address advances by one, the latch and stack are unchanged, and `squash` returns to 0.
- R10: A fifth nested call overwrites the oldest stack entry without any signal. Five returns then yield call addresses 5, 4, 3, 2 and 5 again.
- R11: A return with no matching call pops whatever entry the circular pointer reaches after stepping back one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 3 | Control op of the executing instruction (0..7 as in R2..R9) |
| op_far | input | 11 | Jump/call target field |
| op_byte | input | 8 | Data byte for latch or low-byte write |
| bit_val | input | 1 | Value of the bit tested by a skip |
| fetch_addr | output | 13 | Program address fetched this cycle |
| squash | output | 1 | Executing instruction is nullified |

## Verification
The interesting overlap is a transfer op code arriving in the same cycle as a nullified slot. It happens when a taken skip or a transfer is followed directly by a jump, call, return, latch write or low-byte write. The bench drives exactly such pairs. A behavioural reference model then shows that the fetch address only steps by one and that the later jumps use the unchanged latch and stack. Long random op streams also produce these collisions together with stack wrap, and every cycle is compared against the model.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_LATCH    = 3'd1,
        OP_SKIP_SET = 3'd2,
        OP_SKIP_CLR = 3'd3,
        OP_JUMP     = 3'd4,
        OP_CALL     = 3'd5,
        OP_RET      = 3'd6,
        OP_LOW_WR   = 3'd7
    } op_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_BUBBLE = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        SEL_INC   = 2'd0,
        SEL_FAR   = 2'd1,
        SEL_STACK = 2'd2,
        SEL_LOW   = 2'd3
    } pc_sel_e;

    typedef struct packed {
        pc_sel_e sel;
        logic    push;
        logic    pop;
        logic    latch_we;
    } seq_ctl_t;

endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
    import pcseq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     op_code,
    input  logic           bit_val,
    output seq_ctl_t       ctl,
    output logic           squash
);

    seq_state_e state_q;
    seq_state_e state_d;
    op_e        op;

    assign op = op_e'(op_code);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BUBBLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_BUBBLE: state_d = ST_RUN;
            ST_RUN: begin
                unique case (op)
                    OP_NOP, OP_LATCH: state_d = ST_RUN;
                    OP_SKIP_SET:      state_d = bit_val ? ST_BUBBLE : ST_RUN;
                    OP_SKIP_CLR:      state_d = bit_val ? ST_RUN : ST_BUBBLE;
                    OP_JUMP, OP_CALL,
                    OP_RET, OP_LOW_WR: state_d = ST_BUBBLE;
                    default:          state_d = ST_RUN;
                endcase
            end
            default: state_d = ST_BUBBLE;
        endcase
    end

    // outputs
    always_comb begin
        ctl          = '0;
        ctl.sel      = SEL_INC;
        squash       = 1'b0;
        unique case (state_q)
            ST_BUBBLE: begin
                squash = 1'b1;
            end
            ST_RUN: begin
                unique case (op)
                    OP_LATCH:  ctl.latch_we = 1'b1;
                    OP_JUMP:   ctl.sel = SEL_FAR;
                    OP_CALL: begin
                        ctl.sel  = SEL_FAR;
                        ctl.push = 1'b1;
                    end
                    OP_RET: begin
                        ctl.sel = SEL_STACK;
                        ctl.pop = 1'b1;
                    end
                    OP_LOW_WR: ctl.sel = SEL_LOW;
                    default:   ctl.sel = SEL_INC;
                endcase
            end
            default: squash = 1'b1;
        endcase
    end

endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
    parameter int PC_W  = 13,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [PC_W-1:0] push_val,
    output logic [PC_W-1:0] top_val
);

    localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] sp_prev;
    logic [PC_W-1:0] slot_q [DEPTH];

    assign sp_prev = sp_q - SP_W'(1);
    assign top_val = slot_q[sp_prev];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (push) begin
            sp_q <= sp_q + SP_W'(1);
        end else if (pop) begin
            sp_q <= sp_prev;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (push && (sp_q == SP_W'(g))) begin
                slot_q[g] <= push_val;
            end
        end
    end

endmodule

// File: rtl/pcseq_addr.sv
module pcseq_addr
    import pcseq_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LOW_W = 8,
    parameter int FAR_W = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  seq_ctl_t              ctl,
    input  logic [FAR_W-1:0]      far,
    input  logic [LOW_W-1:0]      low_byte,
    input  logic [PC_W-1:0]       stack_top,
    output logic [PC_W-1:0]       pc,
    output logic [PC_W-LOW_W-1:0] hi_latch
);

    localparam int LAT_W  = PC_W - LOW_W;
    localparam int FAR_HI = PC_W - FAR_W;

    logic [PC_W-1:0] pc_nx;

    always_comb begin
        pc_nx = pc + PC_W'(1);
        unique case (ctl.sel)
            SEL_INC:   pc_nx = pc + PC_W'(1);
            SEL_FAR:   pc_nx = {hi_latch[LAT_W-1 -: FAR_HI], far};
            SEL_STACK: pc_nx = stack_top;
            SEL_LOW:   pc_nx = {hi_latch, low_byte};
            default:   pc_nx = pc + PC_W'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            hi_latch <= '0;
        end else begin
            pc <= pc_nx;
            if (ctl.latch_we) begin
                hi_latch <= low_byte[LAT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LOW_W = 8,
    parameter int FAR_W = 11,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_code,
    input  logic [FAR_W-1:0] op_far,
    input  logic [LOW_W-1:0] op_byte,
    input  logic             bit_val,
    output logic [PC_W-1:0]  fetch_addr,
    output logic             squash
);

    localparam int LAT_W = PC_W - LOW_W;

    seq_ctl_t         ctl;
    logic [PC_W-1:0]  stack_top;
    logic [LAT_W-1:0] hi_latch;

    pcseq_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_code (op_code),
        .bit_val (bit_val),
        .ctl     (ctl),
        .squash  (squash)
    );

    pcseq_stack #(
        .PC_W  (PC_W),
        .DEPTH (DEPTH)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ctl.push),
        .pop      (ctl.pop),
        .push_val (fetch_addr),
        .top_val  (stack_top)
    );

    pcseq_addr #(
        .PC_W  (PC_W),
        .LOW_W (LOW_W),
        .FAR_W (FAR_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .far       (op_far),
        .low_byte  (op_byte),
        .stack_top (stack_top),
        .pc        (fetch_addr),
        .hi_latch  (hi_latch)
    );

endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
    parameter int PC_W  = 13,
    parameter int LOW_W = 8,
    parameter int FAR_W = 11
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2:0]            op_code,
    input logic [FAR_W-1:0]      op_far,
    input logic [LOW_W-1:0]      op_byte,
    input logic                  bit_val,
    input logic [PC_W-1:0]       fetch_addr,
    input logic                  squash,
    input logic [PC_W-LOW_W-1:0] hi_latch
);

    localparam int LAT_W  = PC_W - LOW_W;
    localparam int FAR_HI = PC_W - FAR_W;

    logic live;
    assign live = !squash;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        live && (op_code <= 3'd1) |=> !squash && fetch_addr == PC_W'($past(fetch_addr) + 1'b1)); // R2

    AST_SKIP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        live && ((op_code == 3'd2 && bit_val) || (op_code == 3'd3 && !bit_val))
        |=> squash && fetch_addr == PC_W'($past(fetch_addr) + 1'b1)); // R3

    AST_JUMP_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        live && (op_code == 3'd4 || op_code == 3'd5)
        |=> squash && fetch_addr == {$past(hi_latch[LAT_W-1 -: FAR_HI]), $past(op_far)}); // R4

    AST_LOW_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        live && op_code == 3'd7 |=> squash && fetch_addr == {$past(hi_latch), $past(op_byte)}); // R7

    AST_BUBBLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> !squash && fetch_addr == PC_W'($past(fetch_addr) + 1'b1)); // R9

    AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        squash || op_code != 3'd1 |=> $stable(hi_latch)); // R8

    AST_RETURN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        live && op_code == 3'd6 |=> squash); // R6

endmodule

bind pcseq_top pcseq_checker #(
    .PC_W  (PC_W),
    .LOW_W (LOW_W),
    .FAR_W (FAR_W)
) u_pcseq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_code    (op_code),
    .op_far     (op_far),
    .op_byte    (op_byte),
    .bit_val    (bit_val),
    .fetch_addr (fetch_addr),
    .squash     (squash),
    .hi_latch   (hi_latch)
);

// File: tb/pcseq_top_bench.sv
module pcseq_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [10:0] op_far = '0;
    logic [7:0]  op_byte = '0;
    logic        bit_val = 1'b0;
    logic [12:0] fetch_addr;
    logic        squash;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 0;

    // reference model state
    int m_pc  = 0;
    bit m_sq  = 1;
    int m_lat = 0;
    int m_stk [4] = '{0, 0, 0, 0};
    int m_sp  = 0;

    always #4 clk = ~clk;

    pcseq_top u_pcseq_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_code    (op_code),
        .op_far     (op_far),
        .op_byte    (op_byte),
        .bit_val    (bit_val),
        .fetch_addr (fetch_addr),
        .squash     (squash)
    );

    task automatic compare(input string req);
        n_cmp++;
        if (fetch_addr !== 13'(m_pc) || squash !== m_sq) begin
            n_bad++;
            $display("FAIL %s: fetch_addr=%h squash=%b expected fetch_addr=%h squash=%b",
                     req, fetch_addr, squash, 13'(m_pc), m_sq);
        end
    endtask

    task automatic model_update(input int op, input int far, input int byt, input bit bv);
        if (m_sq) begin
            m_pc = (m_pc + 1) % 8192;
            m_sq = 0;
        end else begin
            case (op)
                0: begin m_pc = (m_pc + 1) % 8192; m_sq = 0; end
                1: begin m_pc = (m_pc + 1) % 8192; m_sq = 0; m_lat = byt % 32; end
                2: begin m_pc = (m_pc + 1) % 8192; m_sq = bv; end
                3: begin m_pc = (m_pc + 1) % 8192; m_sq = !bv; end
                4: begin m_pc = ((m_lat / 8) * 2048) + far; m_sq = 1; end
                5: begin
                    m_stk[m_sp] = m_pc;
                    m_sp = (m_sp + 1) % 4;
                    m_pc = ((m_lat / 8) * 2048) + far;
                    m_sq = 1;
                end
                6: begin
                    m_sp = (m_sp + 3) % 4;
                    m_pc = m_stk[m_sp];
                    m_sq = 1;
                end
                default: begin m_pc = (m_lat * 256) + byt; m_sq = 1; end
            endcase
        end
    endtask

    // one instruction cycle: drive after negedge, model at posedge, compare at next negedge
    task automatic step(input int op, input int far, input int byt, input bit bv, input string req);
        op_code = 3'(op);
        op_far  = 11'(far);
        op_byte = 8'(byt);
        bit_val = bv;
        @(posedge clk);
        model_update(op, far, byt, bv);
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1");                               // reset state

        step(0, 0, 0, 0, "R9");                      // reset bubble drops
        step(0, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R2");                      // latch write of 0 steps by one
        // R1: latch still 0 after reset, jump has zero upper bits
        step(4, 11'h7AB, 0, 0, "R1");
        step(0, 0, 0, 0, "R9");

        // skips
        step(2, 0, 0, 1, "R3");                      // taken
        step(4, 11'h055, 0, 0, "R9");                // jump in nullified slot ignored
        step(2, 0, 0, 0, "R3");                      // not taken
        step(3, 0, 0, 0, "R3");                      // taken
        step(7, 0, 8'h44, 0, "R9");                  // low write ignored
        step(3, 0, 0, 1, "R3");                      // not taken

        // latch then transfers
        step(1, 0, 8'hFF, 0, "R8");                  // latch = 1F
        step(4, 11'h123, 0, 0, "R4");                // 0x1923
        step(1, 0, 8'h00, 0, "R9");                  // latch write dropped in bubble
        step(7, 0, 8'hFE, 0, "R7");                  // 0x1FFE, latch still 1F
        step(0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, "R2");                      // wrap to 0
        step(0, 0, 0, 0, "R2");
        step(1, 0, 8'h08, 0, "R8");                  // latch = 08, bits 4:3 = 01
        step(4, 11'h010, 0, 0, "R8");

        // nested calls beyond depth
        step(0, 0, 0, 0, "R9");
        for (int i = 0; i < 5; i++) begin
            step(5, 11'h100 + i * 16, 0, 0, "R5");
            step(5, 11'h3FF, 0, 0, "R9");            // call in bubble ignored
        end
        for (int i = 0; i < 5; i++) begin
            step(6, 0, 0, 0, "R10");
            step(0, 0, 0, 0, "R9");
        end
        step(6, 0, 0, 0, "R11");                     // underflow takes stale slot
        step(0, 0, 0, 0, "R9");
        step(5, 11'h222, 0, 0, "R5");
        step(0, 0, 0, 0, "R9");
        step(6, 0, 0, 0, "R6");
        step(0, 0, 0, 0, "R9");

        // random stream
        for (int i = 0; i < 400; i++) begin
            step(int'($urandom_range(0, 7)), int'($urandom_range(0, 2047)),
                 int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)), "R2..R11 random");
        end

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule